// File: doc/BRIEF.md
# E3 Transmit Payload Ingest with Slaved Frame Timing

This block is the serial payload entry point of an E3 transmit framer that uses the byte-oriented overhead layout, in the arrangement where the system side decides when each frame begins. On every rising edge of the transmit input clock (nominally 34.368 MHz) it takes one bit from the serial input. It tracks the position of that bit inside a 4296-bit frame and hands the bit to the downstream framer one cycle later. Each handed-over bit carries a payload flag and a start-of-frame mark. The downstream framer fills the slots whose payload flag is low with overhead bytes.

The system side pulses a frame reference input for one bit period on the first bit of each frame, and the block restarts its position count on the rising edge of that input. The frame reference must be synchronous to the transmit clock; the block does not resynchronise it. One bit period ahead of each overhead slot the block raises an overhead indicator, so that the system side withholds payload until the indicator drops. The two framing bytes at the head of the frame form one 16-bit overhead run. Five more single overhead bytes sit at byte offsets given by a parameter. When a restart arrives anywhere other than at the expected frame boundary, the block sets a sticky misalignment flag.

Top module: `e3_txpay_ingest`

## Requirements
- R1: While reset is asserted and right after it, pl_valid, pl_sof, pl_bit and misalign are 0 and the bit position is 0. With fref_in low, oh_ind is therefore 1, because position 1 is overhead.
- R2: The bit sampled on ser_in at a rising clock edge appears on pl_bit after that edge and stays there for the following cycle, which is one cycle of latency.
- R3: The bit position advances by one on every clock and wraps from 4295 back to 0 without any frame reference. pl_sof is 1 exactly for the beat that carries position 0.
- R4: A rising edge on fref_in (high now, low in the previous cycle) makes the bit sampled in that same cycle position 0. Holding fref_in high for more cycles causes no further restart.
- R5: oh_ind is 1 in a cycle exactly when the next bit position is overhead. Across the framing bytes at positions 0 to 15, it is high from the cycle of position 4295 through the cycle of position 14, which is 16 consecutive cycles.
- R6: Each single overhead byte k, at byte offset B[k], covers bit positions 8*B[k] to 8*B[k]+7. The default offsets are 202, 269, 336, 403 and 470. For each of these bytes oh_ind is high for 8 consecutive cycles, starting one cycle before the byte.
- R7: pl_valid is 0 for a beat whose position is overhead (the framing bytes or a single overhead byte) and 1 for every other beat.
- R8: misalign becomes 1 one cycle after a rising edge on fref_in that arrives while the block is already aligned and the position is not 0. The first rising edge after reset, and edges that land on position 0, do not set it. Once set it stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit input clock; all sampling on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial payload bit from the system side |
| fref_in | input | 1 | Frame reference; rising edge marks bit position 0 |
| oh_ind | output | 1 | High when the next bit position is an overhead slot |
| pl_bit | output | 1 | Registered bit passed to the downstream framer |
| pl_valid | output | 1 | High when the beat on pl_bit is payload |
| pl_sof | output | 1 | High when the beat on pl_bit is frame position 0 |
| misalign | output | 1 | Sticky flag for a frame reference at an unexpected position |

## Verification
The hardest state to reach from the ports is a late misalignment. The block has to be aligned first, then a reference edge must land off position 0, and only then can the sticky behaviour, and its clearing by reset, be seen. The stimulus runs free and unaligned, locks with a first pulse at an arbitrary position, and delivers two pulses exactly on the boundary, which must not set the flag. It then fires an early pulse and follows it with a long held-high reference. Full frames run between these events, so the overhead lookahead across the wrap from 4295 to 0 is covered both with and without a reference pulse.

// File: rtl/e3tx_pkg.sv
package e3tx_pkg;

    localparam int E3_FRAME_BYTES = 537;
    localparam int E3_FAS_BITS    = 16;
    localparam int E3_SGL_COUNT   = 5;
    localparam int E3_IDX_W       = 16;

    typedef logic [E3_IDX_W-1:0] byte_idx_t;

    typedef struct packed {
        logic data;
        logic payload;
        logic sof;
    } beat_t;

    function automatic logic in_fas(input int unsigned bit_pos);
        return bit_pos < E3_FAS_BITS;
    endfunction

endpackage

// File: rtl/e3tx_bit_ctr.sv
module e3tx_bit_ctr #(
    parameter int FRAME_BITS = 4296,
    localparam int PW = $clog2(FRAME_BITS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fref,
    output logic [PW-1:0] pos,
    output logic          rise,
    output logic          realign
);
    localparam logic [PW-1:0] LAST = PW'(FRAME_BITS - 1);

    logic [PW-1:0] cnt;
    logic          fref_q;
    logic          locked;

    assign rise    = fref & ~fref_q;
    assign pos     = rise ? '0 : cnt;
    assign realign = rise & locked & (cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            fref_q <= 1'b0;
            locked <= 1'b0;
        end else begin
            cnt    <= (pos == LAST) ? '0 : pos + 1'b1;
            fref_q <= fref;
            locked <= locked | rise;
        end
    end

    // R3: natural wrap at the end of the frame
    a_r3_wrap: assert property (@(posedge clk) disable iff (rst)
        (!rise && cnt == LAST) |=> cnt == '0);

    // R4: a restart puts the next count at 1
    a_r4_restart: assert property (@(posedge clk) disable iff (rst)
        rise |=> cnt == PW'(1));

endmodule

// File: rtl/e3tx_oh_map.sv
module e3tx_oh_map
    import e3tx_pkg::*;
#(
    parameter int FRAME_BITS = 4296,
    parameter int NUM_SGL    = E3_SGL_COUNT,
    parameter logic [NUM_SGL*E3_IDX_W-1:0] SGL_TABLE = {16'd470, 16'd403, 16'd336, 16'd269, 16'd202},
    localparam int PW = $clog2(FRAME_BITS)
) (
    input  logic [PW-1:0] pos,
    output logic          hit
);
    logic [NUM_SGL-1:0] match;
    byte_idx_t          byte_idx;

    assign byte_idx = E3_IDX_W'(pos >> 3);

    for (genvar i = 0; i < NUM_SGL; i++) begin : g_sgl
        assign match[i] = (byte_idx == SGL_TABLE[i*E3_IDX_W +: E3_IDX_W]);
    end

    assign hit = in_fas(32'(pos)) | (|match);

endmodule

// File: rtl/e3_txpay_ingest.sv
module e3_txpay_ingest
    import e3tx_pkg::*;
#(
    parameter int FRAME_BITS = E3_FRAME_BYTES * 8,
    parameter int NUM_SGL    = E3_SGL_COUNT,
    parameter logic [NUM_SGL*E3_IDX_W-1:0] SGL_TABLE = {16'd470, 16'd403, 16'd336, 16'd269, 16'd202}
) (
    input  logic clk,
    input  logic rst,
    input  logic ser_in,
    input  logic fref_in,
    output logic oh_ind,
    output logic pl_bit,
    output logic pl_valid,
    output logic pl_sof,
    output logic misalign
);
    localparam int PW = $clog2(FRAME_BITS);
    localparam logic [PW-1:0] LAST = PW'(FRAME_BITS - 1);

    logic [PW-1:0] cur_pos;
    logic [PW-1:0] nxt_pos;
    logic          rise;
    logic          realign;
    logic          cur_oh;
    logic          nxt_oh;
    beat_t         beat_q;
    logic          mis_q;

    e3tx_bit_ctr #(.FRAME_BITS(FRAME_BITS)) u_ctr (
        .clk     (clk),
        .rst     (rst),
        .fref    (fref_in),
        .pos     (cur_pos),
        .rise    (rise),
        .realign (realign)
    );

    assign nxt_pos = (cur_pos == LAST) ? '0 : cur_pos + 1'b1;

    e3tx_oh_map #(.FRAME_BITS(FRAME_BITS), .NUM_SGL(NUM_SGL), .SGL_TABLE(SGL_TABLE)) u_map_cur (
        .pos (cur_pos),
        .hit (cur_oh)
    );

    e3tx_oh_map #(.FRAME_BITS(FRAME_BITS), .NUM_SGL(NUM_SGL), .SGL_TABLE(SGL_TABLE)) u_map_nxt (
        .pos (nxt_pos),
        .hit (nxt_oh)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q <= '0;
            mis_q  <= 1'b0;
        end else begin
            beat_q.data    <= ser_in;
            beat_q.payload <= ~cur_oh;
            beat_q.sof     <= (cur_pos == '0);
            mis_q          <= mis_q | realign;
        end
    end

    assign oh_ind   = nxt_oh;
    assign pl_bit   = beat_q.data;
    assign pl_valid = beat_q.payload;
    assign pl_sof   = beat_q.sof;
    assign misalign = mis_q;

    // R2: one-cycle pass-through of the serial bit
    a_r2_latency: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> pl_bit == $past(ser_in));

    // R7: the frame-start beat is always an overhead slot
    a_r7_sof_not_payload: assert property (@(posedge clk) disable iff (rst)
        pl_sof |-> !pl_valid);

    // R8: the misalignment flag never clears outside reset
    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
        misalign |=> misalign);

    // R5: a restart edge always announces the overhead at position 1
    a_r5_restart_ind: assert property (@(posedge clk) disable iff (rst)
        rise |-> oh_ind);

endmodule

// File: tb/e3_txpay_ingest_bench.sv
module e3_txpay_ingest_bench;
    localparam int CLK_P = 10;
    localparam int FB    = 4296;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_in = 1'b0;
    logic fref_in = 1'b0;
    logic oh_ind, pl_bit, pl_valid, pl_sof, misalign;

    int checks = 0;
    int failures = 0;

    int sgl[5] = '{202, 269, 336, 403, 470};

    int mpos = 0;
    bit fprev = 0, locked = 0, sticky = 0;
    bit e_bit = 0, e_vld = 0, e_sof = 0, e_mis = 0;

    e3_txpay_ingest u_e3_txpay_ingest (
        .clk(clk), .rst(rst), .ser_in(ser_in), .fref_in(fref_in),
        .oh_ind(oh_ind), .pl_bit(pl_bit), .pl_valid(pl_valid),
        .pl_sof(pl_sof), .misalign(misalign)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic bit m_oh(input int p);
        bit r = (p < 16);
        foreach (sgl[k]) if (p / 8 == sgl[k]) r = 1;
        return r;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d pos=%0d t=%0t", req, act, exp, mpos, $time);
        end
    endtask

    task automatic model_clear();
        mpos = 0; fprev = 0; locked = 0; sticky = 0;
        e_bit = 0; e_vld = 0; e_sof = 0; e_mis = 0;
    endtask

    task automatic step(input bit f);
        bit s;
        bit r;
        int cur;
        @(negedge clk);
        chk("R2 pl_bit", pl_bit, e_bit);
        chk("R7 R6 pl_valid", pl_valid, e_vld);
        chk("R3 R4 pl_sof", pl_sof, e_sof);
        chk("R8 misalign", misalign, e_mis);
        s = 1'($urandom);
        rst = 1'b0;
        ser_in = s;
        fref_in = f;
        #1;
        r = f && !fprev;
        cur = r ? 0 : mpos;
        chk("R5 R6 oh_ind", oh_ind, m_oh((cur + 1) % FB));
        if (r && locked && mpos != 0) sticky = 1;
        if (r) locked = 1;
        e_bit = s;
        e_vld = !m_oh(cur);
        e_sof = (cur == 0);
        e_mis = sticky;
        mpos = (cur + 1) % FB;
        fprev = f;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step(1'b0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        fref_in = 1'b0;
        @(negedge clk);
        @(negedge clk);
        #1;
        chk("R1 pl_valid", pl_valid, 0);
        chk("R1 pl_sof", pl_sof, 0);
        chk("R1 pl_bit", pl_bit, 0);
        chk("R1 misalign", misalign, 0);
        chk("R1 oh_ind", oh_ind, 1);
        model_clear();
    endtask

    initial begin
        #(CLK_P * 200000);
        failures++;
        $display("FAIL R1 watchdog actual=timeout expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        do_reset();
        run(100);                         // R3 free running, not yet aligned
        step(1'b1);                       // R8 first edge locks without flag
        run(FB - 1);
        step(1'b1);                       // R4 edge exactly at position 0
        run(FB - 1);
        step(1'b1);
        run(700);
        step(1'b1);                       // R8 early edge sets the flag
        run(50);
        for (int i = 0; i < 20; i++) step(1'b1);   // R4 held high: one restart
        run(FB + 900);                    // R3 R5 natural wrap
        do_reset();                       // R1 R8 flag cleared by reset
        run(60);
        step(1'b1);
        run(FB + 20);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule